// File: doc/BRIEF.md
# Two-Channel DMA RAM Address Counter

This block holds the running RAM address for each of two DMA channels. Software sets a 16-bit starting address through a small register bus. Each access is either a full halfword or a single byte. The DMA engine drives the memory with each channel's address output. After every element it moves, the engine strobes that channel's step input, and the stored address then advances by the element size.

A per-channel width input selects the element size. With byte elements the register advances by one. With halfword elements it advances by two, and the address given to memory has bit 0 forced low. Bus reads always return the stored value unchanged.

A per-channel busy input marks a transfer in progress. While busy is high, host writes to that channel are dropped. Step strobes have an effect only while busy is high.

The bus, step, busy and width pins are plain control pins with no handshake. A bus access completes in the cycle it is presented, so there is no back-pressure at any pin. The memory-side address is a level output.

Top module: `dma_ram_addr_regs`

## Requirements
- R1: After reset, the stored value of both channels is 0x0000 and both `mem_addr` fields read 0x0000.
- R2: A halfword access at the channel's even offset writes or reads all 16 bits. Channel 0 uses offsets 2 and 3, and channel 1 uses offsets 4 and 5.
- R3: A byte access at the even offset writes or reads bits 7:0 only. A byte access at the odd offset writes or reads bits 15:8 only. Byte reads return the selected byte in `bus_rdata[7:0]` with the upper 8 bits zero.
- R4: A halfword access at an odd offset, or any access at an offset outside 2..5, changes no register. A read of that kind returns 0x0000.
- R5: In byte mode (`ch_wide`=0), each clock edge with both busy and step high adds 1 to the channel's register.
- R6: In halfword mode (`ch_wide`=1), each clock edge with both busy and step high adds 2 to the channel's register.
- R7: A step strobe while busy is low leaves the register unchanged.
- R8: A bus write to a channel whose busy input is high leaves that channel's register unchanged.
- R9: The increment wraps modulo 2^16. For example, 0xFFFF + 1 gives 0x0000, and 0xFFFE + 2 gives 0x0000.
- R10: In halfword mode, `mem_addr` for that channel equals the stored value with bit 0 cleared. In byte mode it equals the stored value. Bus reads return the stored value including bit 0.
- R11: Accesses and steps on one channel never change the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_off | input | 3 | Byte offset within the register window |
| bus_wdata | input | 16 | Write data; a byte write uses [7:0] for the low byte and [15:8] for the high byte |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read access |
| ch_busy | input | 2 | Per-channel transfer in progress |
| ch_step | input | 2 | Per-channel element-done strobe |
| ch_wide | input | 2 | Per-channel element size: 1 = halfword, 0 = byte |
| mem_addr | output | 32 | Memory-side addresses; channel n in bits [16n+15:16n] |

## Verification
The stepping function is tested with short strobe runs in byte mode and in halfword mode. Comparing the two separates a step of one from a step of two. An odd start address in halfword mode shows that bit 0 is masked on the memory-side address but kept in the stored value. Strobes with busy low, and writes with busy high, show that busy gates both paths and that each gate works in the right direction. Start values of 0xFFFF and 0xFFFE expose any carry or missing wrap. Byte writes and reads at each offset of one channel, with the other channel read back afterwards, show that each byte lane and each channel is decoded independently.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFF_W    = 3;
  localparam int unsigned BASE_OFF = 2;
  localparam int unsigned N_CH     = 2;

  // Step sizes per element width.
  localparam int unsigned STEP_BYTE = 1;
  localparam int unsigned STEP_HALF = 2;

  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LO   = 2'b01,
    LANE_HI   = 2'b10,
    LANE_BOTH = 2'b11
  } lane_e;
endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_addr_pkg::*;
#(
  parameter int unsigned NCH   = N_CH,
  parameter int unsigned OW    = OFF_W,
  parameter int unsigned BASE  = BASE_OFF
) (
  input  logic          bus_en,
  input  logic          bus_half,
  input  logic [OW-1:0] bus_off,
  output logic [NCH-1:0] sel_lo,
  output logic [NCH-1:0] sel_hi
);
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_dec
      localparam logic [OW-1:0] LO_OFF = OW'(BASE + 2 * gi);
      localparam logic [OW-1:0] HI_OFF = OW'(BASE + 2 * gi + 1);
      lane_e lane;
      always_comb begin
        lane = LANE_NONE;
        if (bus_en) begin
          if (bus_off == LO_OFF)
            lane = bus_half ? LANE_BOTH : LANE_LO;
          else if (bus_off == HI_OFF && !bus_half)
            lane = LANE_HI;
        end
      end
      assign sel_lo[gi] = lane[0];
      assign sel_hi[gi] = lane[1];
    end
  endgenerate
endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [AW-1:0] wdata,
  input  logic          busy,
  input  logic          step,
  input  logic          wide,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] mem_addr
);
  localparam int unsigned HALF = AW / 2;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] inc;
  logic          host_ok;

  assign inc     = wide ? AW'(STEP_HALF) : AW'(STEP_BYTE);
  assign host_ok = wr_en && !busy;

  always_comb begin
    addr_d = addr_q;
    if (busy && step) begin
      addr_d = addr_q + inc;
    end else if (host_ok) begin
      if (wr_lo) addr_d[HALF-1:0]  = wdata[HALF-1:0];
      if (wr_hi) addr_d[AW-1:HALF] = wdata[AW-1:HALF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign cur      = addr_q;
  assign mem_addr = wide ? {addr_q[AW-1:1], 1'b0} : addr_q;
endmodule

// File: rtl/dma_addr_rdmux.sv
module dma_addr_rdmux #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 16
) (
  input  logic              rd_en,
  input  logic [NCH-1:0]    sel_lo,
  input  logic [NCH-1:0]    sel_hi,
  input  logic [NCH*AW-1:0] regs,
  output logic [AW-1:0]     rdata
);
  localparam int unsigned HALF = AW / 2;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (sel_lo[i] && sel_hi[i])
          rdata = rdata | regs[i*AW +: AW];
        else if (sel_lo[i])
          rdata = rdata | {{HALF{1'b0}}, regs[i*AW +: HALF]};
        else if (sel_hi[i])
          rdata = rdata | {{HALF{1'b0}}, regs[i*AW+HALF +: HALF]};
      end
    end
  end
endmodule

// File: rtl/dma_ram_addr_regs.sv
module dma_ram_addr_regs
  import dma_addr_pkg::*;
#(
  parameter int unsigned NCH  = N_CH,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned OW   = OFF_W,
  parameter int unsigned BASE = BASE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_half,
  input  logic [OW-1:0]     bus_off,
  input  logic [AW-1:0]     bus_wdata,
  output logic [AW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    ch_busy,
  input  logic [NCH-1:0]    ch_step,
  input  logic [NCH-1:0]    ch_wide,
  output logic [NCH*AW-1:0] mem_addr
);
  logic [NCH-1:0]    sel_lo;
  logic [NCH-1:0]    sel_hi;
  logic [NCH*AW-1:0] cur_flat;
  logic              wr_en;
  logic              rd_en;

  assign wr_en = bus_en && bus_we;
  assign rd_en = bus_en && !bus_we;

  dma_addr_decode #(.NCH(NCH), .OW(OW), .BASE(BASE)) u_dec (
    .bus_en  (bus_en),
    .bus_half(bus_half),
    .bus_off (bus_off),
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      dma_addr_chan #(.AW(AW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lo   (sel_lo[gc]),
        .wr_hi   (sel_hi[gc]),
        .wdata   (bus_wdata),
        .busy    (ch_busy[gc]),
        .step    (ch_step[gc]),
        .wide    (ch_wide[gc]),
        .cur     (cur_flat[gc*AW +: AW]),
        .mem_addr(mem_addr[gc*AW +: AW])
      );
    end
  endgenerate

  dma_addr_rdmux #(.NCH(NCH), .AW(AW)) u_rd (
    .rd_en (rd_en),
    .sel_lo(sel_lo),
    .sel_hi(sel_hi),
    .regs  (cur_flat),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/dma_addr_regs_chk.sv
module dma_addr_regs_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [NCH-1:0]    ch_busy,
  input logic [NCH-1:0]    ch_step,
  input logic [NCH-1:0]    ch_wide,
  input logic [NCH*AW-1:0] mem_addr
);
  genvar gk;
  generate
    for (gk = 0; gk < NCH; gk++) begin : g_k
      AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_busy[gk] && ch_step[gk] && !ch_wide[gk]) |=>
        (ch_wide[gk] || mem_addr[gk*AW +: AW] == $past(mem_addr[gk*AW +: AW]) + AW'(1))); // R5

      AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_busy[gk] && ch_step[gk] && ch_wide[gk]) |=>
        (!ch_wide[gk] || mem_addr[gk*AW +: AW] == $past(mem_addr[gk*AW +: AW]) + AW'(2))); // R6

      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_busy[gk] && !(bus_en && bus_we)) |=>
        (ch_wide[gk] != $past(ch_wide[gk]) || $stable(mem_addr[gk*AW +: AW]))); // R7

      AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_busy[gk] && !ch_step[gk] && bus_en && bus_we) |=>
        (ch_wide[gk] != $past(ch_wide[gk]) || $stable(mem_addr[gk*AW +: AW]))); // R8

      AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wide[gk] |-> (mem_addr[gk*AW] == 1'b0)); // R10
    end
  endgenerate
endmodule

bind dma_ram_addr_regs dma_addr_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_en  (bus_en),
  .bus_we  (bus_we),
  .ch_busy (ch_busy),
  .ch_step (ch_step),
  .ch_wide (ch_wide),
  .mem_addr(mem_addr)
);

// File: tb/tb_dma_ram_addr_regs.sv
module tb_dma_ram_addr_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_half = 1'b0;
  logic [2:0]  bus_off = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  ch_busy = '0;
  logic [1:0]  ch_step = '0;
  logic [1:0]  ch_wide = '0;
  logic [31:0] mem_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ram_addr_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_half(bus_half), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ch_busy(ch_busy), .ch_step(ch_step),
    .ch_wide(ch_wide), .mem_addr(mem_addr)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read value on every read cycle.
  always @(negedge clk) begin
    if (bus_en && !bus_we) begin
      if (sb_q.size() == 0) begin
        check(bus_rdata, 16'hxxxx, "scoreboard underflow");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [2:0] off, input bit half, input logic [15:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 1; bus_half = half; bus_off = off; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] off, input bit half, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 0; bus_half = half; bus_off = off;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic steps(input int ch, input int n, input bit bsy);
    @(posedge clk); #1;
    ch_busy[ch] = bsy; ch_step[ch] = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    ch_step[ch] = 1'b0; ch_busy[ch] = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check(mem_addr[15:0], 16'h0000, "R1 ch0 mem_addr");
    check(mem_addr[31:16], 16'h0000, "R1 ch1 mem_addr");
    rd(3'd2, 1, 16'h0000, "R1 ch0 read");
    rd(3'd4, 1, 16'h0000, "R1 ch1 read");
    // R2 / R11 halfword access
    wr(3'd2, 1, 16'h1234);
    wr(3'd4, 1, 16'hBEEF);
    rd(3'd2, 1, 16'h1234, "R2 ch0 half");
    rd(3'd4, 1, 16'hBEEF, "R2 R11 ch1 half");
    // R3 byte lanes
    wr(3'd3, 0, 16'hAB00);
    rd(3'd2, 1, 16'hAB34, "R3 hi byte write");
    rd(3'd3, 0, 16'h00AB, "R3 hi byte read");
    rd(3'd2, 0, 16'h0034, "R3 lo byte read");
    wr(3'd4, 0, 16'h005A);
    rd(3'd4, 1, 16'hBE5A, "R3 lo byte write");
    // R4 illegal accesses
    wr(3'd3, 1, 16'hFFFF);
    wr(3'd0, 1, 16'hFFFF);
    wr(3'd6, 0, 16'hFFFF);
    rd(3'd3, 1, 16'h0000, "R4 odd half read");
    rd(3'd7, 0, 16'h0000, "R4 out of window read");
    rd(3'd2, 1, 16'hAB34, "R4 ch0 untouched");
    rd(3'd4, 1, 16'hBE5A, "R4 ch1 untouched");
    // R5 byte stepping
    steps(0, 3, 1);
    check(mem_addr[15:0], 16'hAB37, "R5 ch0 three byte steps");
    check(mem_addr[31:16], 16'hBE5A, "R11 ch1 unaffected by ch0 steps");
    // R7 strobe without busy
    steps(0, 2, 0);
    check(mem_addr[15:0], 16'hAB37, "R7 step without busy");
    // R10 / R6 halfword mode, odd start
    wr(3'd4, 1, 16'h1001);
    ch_wide[1] = 1'b1;
    #1 check(mem_addr[31:16], 16'h1000, "R10 wide masks bit0");
    rd(3'd4, 1, 16'h1001, "R10 read keeps bit0");
    steps(1, 2, 1);
    check(mem_addr[31:16], 16'h1004, "R6 two half steps mem");
    rd(3'd4, 1, 16'h1005, "R6 two half steps stored");
    // R8 write while busy
    @(posedge clk); #1 ch_busy[0] = 1'b1;
    wr(3'd2, 1, 16'h0000);
    rd(3'd2, 1, 16'hAB37, "R8 write blocked while busy");
    @(posedge clk); #1 ch_busy[0] = 1'b0;
    // R9 wrap
    wr(3'd2, 1, 16'hFFFF);
    steps(0, 1, 1);
    check(mem_addr[15:0], 16'h0000, "R9 byte wrap");
    wr(3'd4, 1, 16'hFFFE);
    steps(1, 1, 1);
    check(mem_addr[31:16], 16'h0000, "R9 half wrap");
    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) check(16'(sb_q.size()), 16'h0000, "scoreboard leftover");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule